// File: doc/BRIEF.md
# Interrupt Stacking and Vectoring Sequencer

This block sits next to a small 8-bit processor core and handles the core's exception control. It holds the program counter, the stack pointer, the accumulator, the index register and the condition code register. It exposes all five to the core. While the sequencer is idle, the core can load new values into them. At every instruction boundary the sequencer looks at a set of interrupt requests. Each request has its own enable, and the lowest index has the highest priority. If a request is accepted, the sequencer saves a five-byte return frame on a stack that grows downward, writing one byte per cycle. It then sets the interrupt mask bit and reads a 16-bit vector that becomes the new program counter.

When the core asks for a return from interrupt, the sequencer pulls the frame back in the reverse order. It then reads the opcode at the restored program counter. If an enabled request is still waiting and the restored mask allows it, the prefetched opcode is dropped and a new entry starts at once. The index-high register is never saved. Software that changes it must save and restore it.

Every bus access lasts one cycle on a shared 8-bit data bus and 16-bit address bus. The read/write line is high for reads. Instruction decode and arithmetic belong to the core.

Top module: `exc_seq`

## Requirements
- R1: After reset the sequencer is idle with no bus access. PC is 0x0000, SP is SP_RST (0x00FF by default), A and X are 0, and CCR is CCR_RST (0x08, so the mask bit, bit 3, is set).
- R2: Requests are sampled only in a cycle where the idle sequencer sees `insn_done` high. A request held while `insn_done` is low never starts a sequence.
- R3: A request is accepted only when CCR bit 3 is clear and the request's enable bit is set. Otherwise the sequencer stays idle and makes no bus access.
- R4: When several requests qualify, the lowest index is accepted. In the accepting cycle `irq_ack` is high and `ack_id` gives that index.
- R5: An accepted entry writes five bytes, one per cycle, with `bus_rw` low. The bytes are PC[7:0], PC[15:8], X, A and CCR, written at SP, SP-1, SP-2, SP-3 and SP-4. SP ends 5 lower.
- R6: The stacked CCR is the value held before entry. From the cycle after the CCR write, CCR bit 3 is set.
- R7: After the writes, two reads with `bus_rw` high fetch the vector. The high byte comes from VEC_BASE+2*index and the low byte from the next address. The result becomes PC, and the sequencer is idle in the following cycle.
- R8: A return request while idle makes five reads at SP+1 to SP+5. These restore, in order, CCR, A, X, PC[15:8] and PC[7:0]. SP ends 5 higher.
- R9: After the pulls, one read at the restored PC fetches the next opcode. If no request is taken, `op_vld` is high in that cycle with `op_byte` equal to the byte read.
- R10: If a request qualifies under the restored CCR in the prefetch cycle, the opcode is discarded (`op_vld` low). An entry starts in the next cycle and stacks the restored PC.
- R11: `ld_en` loads PC, SP, A, X and CCR only while the sequencer is idle. While it is busy, `ld_en` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NSRC | Interrupt request lines; index 0 has the highest priority |
| irq_en | input | NSRC | Per-source enables |
| insn_done | input | 1 | Current instruction has completed |
| rti_req | input | 1 | Core requests a return from interrupt |
| ld_en | input | 1 | Load the register values below (idle only) |
| ld_pc | input | 16 | PC load value |
| ld_sp | input | 16 | SP load value |
| ld_a | input | 8 | A load value |
| ld_x | input | 8 | X load value |
| ld_ccr | input | 8 | CCR load value |
| bus_din | input | 8 | Read data, sampled in the same cycle |
| bus_en | output | 1 | Sequencer owns the bus this cycle |
| bus_rw | output | 1 | 1 = read, 0 = write |
| bus_addr | output | 16 | Access address |
| bus_dout | output | 8 | Write data |
| busy | output | 1 | A sequence is in progress |
| irq_ack | output | 1 | A request is accepted in this cycle |
| ack_id | output | IDW | Index of the accepted request |
| op_vld | output | 1 | Prefetched opcode is valid |
| op_byte | output | 8 | Prefetched opcode |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| a | output | 8 | Accumulator |
| x | output | 8 | Index register (low byte) |
| ccr | output | 8 | Condition code register |

## Verification
The acceptance outputs `irq_ack` and `ack_id` respond in the same cycle as `insn_done`, or in the prefetch cycle. The bench therefore checks them 1 ns after it drives its inputs. The first stack write appears one cycle after acceptance, and each later bus step appears one cycle after the one before it. The bench checks every step at the falling edge of the cycle that step belongs to. Register results are due one cycle after the last read of a sequence, and the bench checks them at the next falling edge after that read.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CCR_IBIT = 3;

  typedef enum logic [3:0] {
    S_IDLE, S_PSH_PCL, S_PSH_PCH, S_PSH_X, S_PSH_A, S_PSH_CCR,
    S_VEC_H, S_VEC_L,
    S_PUL_CCR, S_PUL_A, S_PUL_X, S_PUL_PCH, S_PUL_PCL, S_FETCH
  } seq_st_e;

  function automatic logic st_push(seq_st_e s);
    return s inside {S_PSH_PCL, S_PSH_PCH, S_PSH_X, S_PSH_A, S_PSH_CCR};
  endfunction

  function automatic logic st_pull(seq_st_e s);
    return s inside {S_PUL_CCR, S_PUL_A, S_PUL_X, S_PUL_PCH, S_PUL_PCL};
  endfunction

  // address of the vector high byte for a source index
  function automatic logic [15:0] vec_hi_addr(logic [15:0] base, logic [7:0] idx);
    return base + {7'd0, idx, 1'b0};
  endfunction

  // pulls pre-increment the stack pointer
  function automatic logic [15:0] pull_addr(logic [15:0] sp_v);
    return sp_v + 16'd1;
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int NSRC = 8,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  input  logic            mask,
  output logic            any_ok,
  output logic [IDW-1:0]  win_id
);
  logic [NSRC-1:0] qual;

  for (genvar i = 0; i < NSRC; i++) begin : g_qual
    assign qual[i] = req[i] & en[i];
  end

  logic found;
  always_comb begin
    win_id = '0;
    found  = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && !found) begin
        win_id = IDW'(i);
        found  = 1'b1;
      end
    end
  end

  assign any_ok = found & ~mask;
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
  import exc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    insn_done,
  input  logic    rti_req,
  input  logic    take,
  output seq_st_e st,
  output logic    accept_evt
);
  seq_st_e nx;

  assign accept_evt = ((st == S_IDLE) && !rti_req && insn_done && take) ||
                      ((st == S_FETCH) && take);

  always_comb begin
    nx = st;
    unique case (st)
      S_IDLE: begin
        if (rti_req)                nx = S_PUL_CCR;
        else if (insn_done && take) nx = S_PSH_PCL;
      end
      S_PSH_PCL: nx = S_PSH_PCH;
      S_PSH_PCH: nx = S_PSH_X;
      S_PSH_X:   nx = S_PSH_A;
      S_PSH_A:   nx = S_PSH_CCR;
      S_PSH_CCR: nx = S_VEC_H;
      S_VEC_H:   nx = S_VEC_L;
      S_VEC_L:   nx = S_IDLE;
      S_PUL_CCR: nx = S_PUL_A;
      S_PUL_A:   nx = S_PUL_X;
      S_PUL_X:   nx = S_PUL_PCH;
      S_PUL_PCH: nx = S_PUL_PCL;
      S_PUL_PCL: nx = S_FETCH;
      S_FETCH:   nx = take ? S_PSH_PCL : S_IDLE;
      default:   nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= nx;
  end
endmodule

// File: rtl/exc_seq.sv
module exc_seq
  import exc_pkg::*;
#(
  parameter int          NSRC     = 8,
  parameter logic [15:0] VEC_BASE = 16'hFFE0,
  parameter logic [15:0] SP_RST   = 16'h00FF,
  parameter logic [7:0]  CCR_RST  = 8'h08,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            insn_done,
  input  logic            rti_req,
  input  logic            ld_en,
  input  logic [15:0]     ld_pc,
  input  logic [15:0]     ld_sp,
  input  logic [7:0]      ld_a,
  input  logic [7:0]      ld_x,
  input  logic [7:0]      ld_ccr,
  input  logic [7:0]      bus_din,
  output logic            bus_en,
  output logic            bus_rw,
  output logic [15:0]     bus_addr,
  output logic [7:0]      bus_dout,
  output logic            busy,
  output logic            irq_ack,
  output logic [IDW-1:0]  ack_id,
  output logic            op_vld,
  output logic [7:0]      op_byte,
  output logic [15:0]     pc,
  output logic [15:0]     sp,
  output logic [7:0]      a,
  output logic [7:0]      x,
  output logic [7:0]      ccr
);
  logic [15:0] pc_q, sp_q;
  logic [7:0]  a_q, x_q, ccr_q;
  logic [IDW-1:0] win_q, win_id;
  logic take, accept_evt;
  seq_st_e st;

  // named internal events for the checker
  logic push_evt, pull_evt, vec_evt, ccr_push_evt, fetch_evt;
  logic [15:0] vec_hi;

  exc_arbiter #(.NSRC(NSRC)) u_arb (
    .req   (irq_req),
    .en    (irq_en),
    .mask  (ccr_q[CCR_IBIT]),
    .any_ok(take),
    .win_id(win_id)
  );

  exc_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .rti_req   (rti_req),
    .take      (take),
    .st        (st),
    .accept_evt(accept_evt)
  );

  assign push_evt     = st_push(st);
  assign pull_evt     = st_pull(st);
  assign vec_evt      = (st == S_VEC_H) || (st == S_VEC_L);
  assign ccr_push_evt = (st == S_PSH_CCR);
  assign fetch_evt    = (st == S_FETCH);
  assign vec_hi       = vec_hi_addr(VEC_BASE, 8'(win_q));

  // bus drive
  always_comb begin
    bus_addr = '0;
    bus_dout = '0;
    unique case (st)
      S_PSH_PCL: bus_dout = pc_q[7:0];
      S_PSH_PCH: bus_dout = pc_q[15:8];
      S_PSH_X:   bus_dout = x_q;
      S_PSH_A:   bus_dout = a_q;
      S_PSH_CCR: bus_dout = ccr_q;
      default:   bus_dout = '0;
    endcase
    if (push_evt)           bus_addr = sp_q;
    else if (pull_evt)      bus_addr = pull_addr(sp_q);
    else if (st == S_VEC_H) bus_addr = vec_hi;
    else if (st == S_VEC_L) bus_addr = vec_hi + 16'd1;
    else if (fetch_evt)     bus_addr = pc_q;
  end

  assign bus_en  = (st != S_IDLE);
  assign bus_rw  = !push_evt;
  assign busy    = (st != S_IDLE);
  assign irq_ack = accept_evt;
  assign ack_id  = win_id;
  assign op_vld  = fetch_evt && !take;
  assign op_byte = bus_din;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      sp_q  <= SP_RST;
      a_q   <= '0;
      x_q   <= '0;
      ccr_q <= CCR_RST;
      win_q <= '0;
    end else begin
      if (st == S_IDLE && ld_en) begin
        pc_q  <= ld_pc;
        sp_q  <= ld_sp;
        a_q   <= ld_a;
        x_q   <= ld_x;
        ccr_q <= ld_ccr;
      end
      if (accept_evt) win_q <= win_id;
      if (push_evt) sp_q <= sp_q - 16'd1;
      if (pull_evt) sp_q <= pull_addr(sp_q);
      unique case (st)
        S_PSH_CCR: ccr_q[CCR_IBIT] <= 1'b1;
        S_VEC_H:   pc_q[15:8]      <= bus_din;
        S_VEC_L:   pc_q[7:0]       <= bus_din;
        S_PUL_CCR: ccr_q           <= bus_din;
        S_PUL_A:   a_q             <= bus_din;
        S_PUL_X:   x_q             <= bus_din;
        S_PUL_PCH: pc_q[15:8]      <= bus_din;
        S_PUL_PCL: pc_q[7:0]       <= bus_din;
        default: ;
      endcase
    end
  end

  assign pc  = pc_q;
  assign sp  = sp_q;
  assign a   = a_q;
  assign x   = x_q;
  assign ccr = ccr_q;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
  import exc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        insn_done,
  input logic        accept_evt,
  input logic        push_evt,
  input logic        pull_evt,
  input logic        vec_evt,
  input logic        ccr_push_evt,
  input logic        fetch_evt,
  input logic        bus_en,
  input logic        bus_rw,
  input logic [15:0] sp,
  input logic [7:0]  ccr
);
  a_r5_push_writes: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |-> (bus_en && !bus_rw));
  a_r5_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
    push_evt |=> (sp == $past(sp) - 16'd1));
  a_r8_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
    pull_evt |=> (sp == $past(sp) + 16'd1));
  a_r8_pull_reads: assert property (@(posedge clk) disable iff (!rst_n)
    pull_evt |-> (bus_en && bus_rw));
  a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_push_evt |=> ccr[CCR_IBIT]);
  a_r7_vec_reads: assert property (@(posedge clk) disable iff (!rst_n)
    vec_evt |-> (bus_en && bus_rw));
  a_r2_accept_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> (insn_done || fetch_evt));
  a_r3_accept_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> !ccr[CCR_IBIT]);
  a_r5_push_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> push_evt);
endmodule

bind exc_seq exc_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .insn_done   (insn_done),
  .accept_evt  (accept_evt),
  .push_evt    (push_evt),
  .pull_evt    (pull_evt),
  .vec_evt     (vec_evt),
  .ccr_push_evt(ccr_push_evt),
  .fetch_evt   (fetch_evt),
  .bus_en      (bus_en),
  .bus_rw      (bus_rw),
  .sp          (sp),
  .ccr         (ccr)
);

// File: tb/exc_seq_test.sv
module exc_seq_test;
  localparam int CLK_P = 10;
  localparam int NSRC = 8;
  localparam int IDW = 3;
  localparam logic [15:0] VB = 16'hFFE0;

  logic clk = 0, rst_n = 0;
  logic [NSRC-1:0] irq_req = '0, irq_en = '0;
  logic insn_done = 0, rti_req = 0, ld_en = 0;
  logic [15:0] ld_pc = '0, ld_sp = '0;
  logic [7:0] ld_a = '0, ld_x = '0, ld_ccr = '0;
  logic [7:0] bus_din;
  logic bus_en, bus_rw, busy, irq_ack, op_vld;
  logic [15:0] bus_addr, pc, sp;
  logic [7:0] bus_dout, op_byte, a, x, ccr;
  logic [IDW-1:0] ack_id;

  exc_seq #(.NSRC(NSRC), .VEC_BASE(VB)) uut (.*);

  always #(CLK_P/2) clk = ~clk;

  // bench memory
  logic [7:0] stk [256];
  logic [7:0] vtab [16];
  logic [7:0] exp_stk [256];

  function automatic logic [7:0] code_at(logic [15:0] ad);
    return ad[7:0] ^ ad[15:8] ^ 8'hA5;
  endfunction

  always_comb begin
    if (bus_addr[15:8] == 8'h00) bus_din = stk[bus_addr[7:0]];
    else if (bus_addr >= VB)     bus_din = vtab[bus_addr[3:0]];
    else                         bus_din = code_at(bus_addr);
  end

  always @(posedge clk) if (bus_en && !bus_rw && bus_addr[15:8] == 8'h00)
    stk[bus_addr[7:0]] <= bus_dout;

  int n_chk = 0, n_err = 0;
  logic [15:0] m_pc, m_sp;
  logic [7:0] m_a, m_x, m_ccr;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] ex);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, ex);
    end
  endtask

  function automatic int first_src(logic [NSRC-1:0] q);
    for (int i = NSRC - 1; i >= 0; i--) if (q[i]) first_src = i;
  endfunction

  task automatic load(input logic [15:0] p, input logic [15:0] s,
                      input logic [7:0] av, input logic [7:0] xv, input logic [7:0] cv);
    @(negedge clk);
    ld_en = 1; ld_pc = p; ld_sp = s; ld_a = av; ld_x = xv; ld_ccr = cv;
    @(negedge clk);
    ld_en = 0;
    m_pc = p; m_sp = s; m_a = av; m_x = xv; m_ccr = cv;
    chk(pc == p && sp == s && a == av && x == xv && ccr == cv, "R11 idle load",
        {pc, sp}, {p, s});
  endtask

  // caller is in the accepting cycle, just after the falling edge
  task automatic entry_seq(input int id, input bit poke);
    logic [15:0] va;
    logic [7:0] fr [5];
    va = VB + 16'(2 * id);
    #1;
    chk(irq_ack === 1'b1, "R4 ack", 32'(irq_ack), 1);
    chk(int'(ack_id) == id, "R4 id", 32'(ack_id), id);
    fr = '{m_pc[7:0], m_pc[15:8], m_x, m_a, m_ccr};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      insn_done = 0;
      chk(bus_en && !bus_rw && bus_addr == m_sp - 16'(k) && bus_dout == fr[k], "R5 push",
          {bus_rw, 7'd0, bus_addr, bus_dout}, {8'd0, m_sp - 16'(k), fr[k]});
      exp_stk[8'(m_sp - 16'(k))] = fr[k];
    end
    @(negedge clk);
    chk(bus_en && bus_rw && bus_addr == va, "R7 vec hi", {16'd0, bus_addr}, {16'd0, va});
    if (poke) begin
      ld_en = 1; ld_pc = ~m_pc; ld_sp = 16'h0011; ld_a = ~m_a; ld_x = ~m_x; ld_ccr = 8'h00;
    end
    @(negedge clk);
    ld_en = 0;
    chk(bus_en && bus_rw && bus_addr == va + 16'd1, "R7 vec lo", {16'd0, bus_addr},
        {16'd0, va + 16'd1});
    m_sp = m_sp - 16'd5;
    m_ccr[3] = 1'b1;
    m_pc = {vtab[va[3:0]], vtab[va[3:0] + 4'd1]};
    @(negedge clk);
    chk(!busy && !bus_en, "R7 idle", {31'd0, busy}, 0);
    chk(pc == m_pc, "R7 pc", {16'd0, pc}, {16'd0, m_pc});
    chk(sp == m_sp, "R5 sp", {16'd0, sp}, {16'd0, m_sp});
    chk(ccr == m_ccr, "R6 mask", {24'd0, ccr}, {24'd0, m_ccr});
    chk(a == m_a && x == m_x, "R11 busy load ignored", {16'd0, a, x}, {16'd0, m_a, m_x});
  endtask

  task automatic rti_seq(input bit pend, input int id);
    logic [7:0] v;
    @(negedge clk);
    rti_req = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      rti_req = 0;
      chk(bus_en && bus_rw && bus_addr == m_sp + 16'(k + 1), "R8 pull",
          {16'd0, bus_addr}, {16'd0, m_sp + 16'(k + 1)});
      v = exp_stk[8'(m_sp + 16'(k + 1))];
      case (k)
        0: m_ccr = v;
        1: m_a = v;
        2: m_x = v;
        3: m_pc[15:8] = v;
        default: m_pc[7:0] = v;
      endcase
    end
    m_sp = m_sp + 16'd5;
    @(negedge clk);
    chk(bus_en && bus_rw && bus_addr == m_pc, "R9 prefetch addr", {16'd0, bus_addr},
        {16'd0, m_pc});
    if (pend) begin
      chk(!op_vld, "R10 opcode dropped", {31'd0, op_vld}, 0);
      entry_seq(id, 0);
    end else begin
      chk(op_vld && op_byte == code_at(m_pc), "R9 opcode", {23'd0, op_vld, op_byte},
          {23'd0, 1'b1, code_at(m_pc)});
      @(negedge clk);
      chk(!busy && pc == m_pc && sp == m_sp && ccr == m_ccr && a == m_a && x == m_x,
          "R8 restore", {pc, ccr, a}, {m_pc, m_ccr, m_a});
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [NSRC-1:0] q;
    bit keep;
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) vtab[i] = 8'($urandom);
    for (int i = 0; i < 256; i++) begin stk[i] = 8'h00; exp_stk[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !bus_en && pc == 16'h0 && sp == 16'h00FF && a == 0 && x == 0 && ccr == 8'h08,
        "R1 reset", {pc, sp}, {16'h0, 16'h00FF});

    // R3: masked after reset
    irq_req = 8'h01; irq_en = 8'hFF;
    insn_done = 1; #1;
    chk(!irq_ack, "R3 masked ack", {31'd0, irq_ack}, 0);
    @(negedge clk); insn_done = 0;
    chk(!busy && !bus_en, "R3 masked idle", {31'd0, busy}, 0);

    // R2: held request without boundary
    load(16'h1234, 16'h00F0, 8'h11, 8'h22, 8'h00);
    irq_req = 8'b0000_0110;
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !bus_en, "R2 no boundary", {31'd0, busy}, 0);
    end
    // R4 priority, R11 poke during entry
    insn_done = 1;
    entry_seq(1, 1);
    irq_req = '0;
    rti_seq(0, 0);

    // R3: disabled source
    irq_req = 8'h80; irq_en = 8'h7F;
    @(negedge clk); insn_done = 1; #1;
    chk(!irq_ack, "R3 disabled ack", {31'd0, irq_ack}, 0);
    @(negedge clk); insn_done = 0;
    chk(!busy, "R3 disabled idle", {31'd0, busy}, 0);

    // R10 directed: request kept through the return
    irq_en = 8'hFF; irq_req = 8'h80;
    @(negedge clk); insn_done = 1;
    entry_seq(7, 0);
    rti_seq(1, 7);
    irq_req = '0;
    rti_seq(0, 0);

    // constrained random
    for (int it = 0; it < 60; it++) begin
      load(16'($urandom), 16'h0040 + 16'($urandom_range(0, 159)), 8'($urandom),
           8'($urandom), 8'($urandom));
      irq_req = NSRC'($urandom);
      irq_en = NSRC'($urandom);
      q = irq_req & irq_en;
      @(negedge clk); insn_done = 1;
      if (!m_ccr[3] && (q != '0)) begin
        entry_seq(first_src(q), 0);
        keep = 1'($urandom);
        if (!keep) irq_req = '0;
        rti_seq(keep, first_src(q));
        if (keep) begin
          irq_req = '0;
          rti_seq(0, 0);
        end
      end else begin
        #1;
        chk(!irq_ack, "R3 random no accept", {31'd0, irq_ack}, 0);
        @(negedge clk); insn_done = 0;
        chk(!busy && !bus_en, "R3 random idle", {31'd0, busy}, 0);
      end
      irq_req = '0;
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule